// File: doc/BRIEF.md
# Coherent Two-Byte Result Holder

This block keeps a 10-bit conversion result in two byte-wide registers that a byte-wide bus reads one at a time. Software that needs the full result reads the low byte first and then the high byte. The block makes sure both bytes it returns come from the same conversion.

Reading the low byte freezes both registers. They stay frozen until the high byte is read. A result that arrives while the registers are frozen is thrown away, but the interrupt-flag set pulse still fires for it.

The result can be placed in either of two layouts. In the right-aligned layout the high byte holds only the two top bits. In the left-aligned layout the high byte holds the top eight bits, so a reader that needs only eight bits can read the high byte alone. The layout is chosen when a result is stored. Conversion logic and address decoding are outside this block; it sees only per-byte read strobes.

Top module: `res_split_lock`

## Requirements
- R1: After the synchronous active-high reset, both byte outputs and `irq_set` are 0 and the registers are unfrozen.
- R2: With `left_adj`=0 at capture, `byte_hi` = {6'b0, data[9:8]} and `byte_lo` = data[7:0]. Both are visible on the cycle after the accepted strobe.
- R3: With `left_adj`=1 at capture, `byte_hi` = data[9:2] and `byte_lo` = {data[1:0], 6'b0}.
- R4: A cycle with `rd_lo`=1 and `rd_hi`=0 freezes the registers from the next cycle. While frozen, `res_valid` strobes leave both bytes unchanged and their results are lost.
- R5: A cycle with `rd_hi`=1 unfreezes the registers, so a strobe in a later cycle is stored.
- R6: `irq_set` is 1 in the cycle after every cycle with `res_valid`=1, whether the result was stored or dropped, and is 0 otherwise.
- R7: Reads of the high byte alone never freeze the registers.
- R8: A strobe in the same cycle as `rd_hi` or `rd_lo` is dropped, and the read sees the old bytes.
- R9: `rd_lo` and `rd_hi` together in one cycle leave the registers unfrozen.
- R10: A change of `left_adj` after capture does not alter the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | Conversion-complete strobe |
| res_data | input | 10 | Conversion result |
| left_adj | input | 1 | 1 selects the left-aligned layout |
| rd_lo | input | 1 | Bus read of the low byte |
| rd_hi | input | 1 | Bus read of the high byte |
| byte_lo | output | 8 | Low result byte |
| byte_hi | output | 8 | High result byte |
| irq_set | output | 1 | One-cycle pulse that sets the interrupt flag |

## Verification
The bench drives a strobe during the frozen window. A design that ignored the freeze would return a high byte from a newer conversion than the low byte, and one that dropped the pulse would lose the interrupt. It also drives a strobe in the same cycle as each read strobe, which exposes a design that lets a late result slip in beside a read. It checks that high-only reads in the left-aligned layout never freeze the registers, which catches a lock that fires on any read. It also checks that changing the layout after capture leaves the stored bytes as they were, which catches a design that formats bytes on the fly.

// File: rtl/res_lock_pkg.sv
package res_lock_pkg;
  typedef enum logic {
    OPEN   = 1'b0,
    FROZEN = 1'b1
  } lock_state_t;
endpackage

// File: rtl/res_byte_pack.sv
module res_byte_pack #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res,
  input  logic              left_adj,
  output logic [BYTE_W-1:0] hi,
  output logic [BYTE_W-1:0] lo
);
  localparam int EXTRA = RES_W - BYTE_W;

  always_comb begin
    hi = '0;
    lo = '0;
    if (left_adj) begin
      for (int i = 0; i < BYTE_W; i++) hi[i] = res[i+EXTRA];
      for (int i = 0; i < EXTRA; i++) lo[i+BYTE_W-EXTRA] = res[i];
    end else begin
      for (int i = 0; i < BYTE_W; i++) lo[i] = res[i];
      for (int i = 0; i < EXTRA; i++) hi[i] = res[i+BYTE_W];
    end
  end
endmodule

// File: rtl/res_lock_fsm.sv
module res_lock_fsm
  import res_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        res_valid,
  input  logic        rd_lo,
  input  logic        rd_hi,
  output lock_state_t state,
  output logic        accept
);
  always_ff @(posedge clk) begin
    if (rst) state <= OPEN;
    else if (rd_hi) state <= OPEN;
    else if (rd_lo) state <= FROZEN;
  end

  assign accept = res_valid && (state == OPEN) && !rd_lo && !rd_hi;

  assert_lo_freezes_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !rd_hi) |=> state == FROZEN);
  assert_hi_opens_R5: assert property (@(posedge clk) disable iff (rst)
    rd_hi |=> state == OPEN);
  assert_hi_only_open_R7: assert property (@(posedge clk) disable iff (rst)
    (state == OPEN && !rd_lo) |=> state == OPEN);
endmodule

// File: rtl/res_split_lock.sv
module res_split_lock
  import res_lock_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic              left_adj,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] byte_lo,
  output logic [BYTE_W-1:0] byte_hi,
  output logic              irq_set
);
  localparam int EXTRA = RES_W - BYTE_W;

  lock_state_t       state;
  logic              accept;
  logic [BYTE_W-1:0] pk_hi, pk_lo;

  res_lock_fsm i_fsm (
    .clk(clk), .rst(rst), .res_valid(res_valid),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .state(state), .accept(accept)
  );

  res_byte_pack #(.RES_W(RES_W), .BYTE_W(BYTE_W)) i_pack (
    .res(res_data), .left_adj(left_adj), .hi(pk_hi), .lo(pk_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_lo <= '0;
      byte_hi <= '0;
      irq_set <= 1'b0;
    end else begin
      irq_set <= res_valid;
      if (accept) begin
        byte_lo <= pk_lo;
        byte_hi <= pk_hi;
      end
    end
  end

  assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (state == FROZEN && res_valid) |=> ($stable(byte_lo) && $stable(byte_hi)));
  assert_irq_every_R6: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> irq_set);
  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> !irq_set);
  assert_read_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_lo || rd_hi) |=> ($stable(byte_lo) && $stable(byte_hi)));
  assert_fmt_left_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && left_adj) |=> byte_hi == $past(res_data[RES_W-1 -: BYTE_W]));
  assert_fmt_right_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && !left_adj) |=> (byte_lo == $past(res_data[BYTE_W-1:0])
                               && byte_hi[BYTE_W-1:EXTRA] == '0));
endmodule

// File: tb/test_res_split_lock.sv
module test_res_split_lock;
  logic clk = 1'b0;
  logic rst, res_valid, left_adj, rd_lo, rd_hi;
  logic [9:0] res_data;
  logic [7:0] byte_lo, byte_hi;
  logic irq_set;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] e_lo, e_hi;
  logic e_irq, e_lock;

  always #10 clk = ~clk;

  res_split_lock i_res_split_lock (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .left_adj(left_adj), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .byte_lo(byte_lo), .byte_hi(byte_hi), .irq_set(irq_set)
  );

  function automatic logic [7:0] f_hi(logic [9:0] d, logic la);
    return la ? d[9:2] : {6'b0, d[9:8]};
  endfunction
  function automatic logic [7:0] f_lo(logic [9:0] d, logic la);
    return la ? {d[1:0], 6'b0} : d[7:0];
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic v, logic [9:0] d, logic la, logic rl, logic rh);
    @(negedge clk);
    res_valid = v; res_data = d; left_adj = la; rd_lo = rl; rd_hi = rh;
    @(posedge clk);
    e_irq = v;
    if (v && !e_lock && !rl && !rh) begin
      e_hi = f_hi(d, la);
      e_lo = f_lo(d, la);
    end
    e_lock = (e_lock | rl) & ~rh;
    #5;
    chk(tag, "byte_lo", byte_lo, e_lo);
    chk(tag, "byte_hi", byte_hi, e_hi);
    chk(tag, "irq_set", {7'b0, irq_set}, {7'b0, e_irq});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; res_valid = 0; res_data = '0; left_adj = 0; rd_lo = 0; rd_hi = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    e_lo = 0; e_hi = 0; e_irq = 0; e_lock = 0;
    chk("R1", "byte_lo", byte_lo, 8'h00);
    chk("R1", "byte_hi", byte_hi, 8'h00);
    chk("R1", "irq_set", {7'b0, irq_set}, 8'h00);
    // R1: unfrozen after reset, so the first strobe is stored
    step("R1", 1, 10'h2A5, 0, 0, 0);
    step("R2", 1, 10'h2A5, 0, 0, 0);   // hi=02 lo=A5
    step("R3", 1, 10'h2A5, 1, 0, 0);   // hi=A9 lo=40
    step("R10", 0, 10'h000, 0, 0, 0);  // layout change, bytes kept
    step("R4", 0, 10'h000, 1, 1, 0);   // freeze
    step("R4", 1, 10'h155, 0, 0, 0);   // dropped, irq still set
    step("R6", 1, 10'h3FF, 1, 0, 0);   // dropped, irq still set
    step("R5", 0, 10'h000, 0, 0, 1);   // unfreeze
    step("R5", 1, 10'h155, 0, 0, 0);   // stored
    step("R7", 0, 10'h000, 1, 0, 1);   // high-only read
    step("R7", 1, 10'h3C3, 1, 0, 1);   // R8: strobe with rd_hi dropped
    step("R7", 1, 10'h0F0, 1, 0, 0);   // still open: stored
    step("R8", 1, 10'h2AA, 1, 1, 0);   // strobe with rd_lo dropped, freezes
    step("R8", 0, 10'h000, 1, 0, 1);
    step("R9", 0, 10'h000, 0, 1, 1);   // both reads: open
    step("R9", 1, 10'h1E7, 0, 0, 0);   // stored
    step("R6", 0, 10'h000, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic v, la, rl, rh;
      logic [9:0] d;
      v  = ($urandom % 3) != 0;
      d  = 10'($urandom);
      la = 1'($urandom);
      rl = ($urandom % 5) == 0;
      rh = ($urandom % 5) == 0;
      step("R4/R5/R6 random", v, d, la, rl, rh);
    end
    finish_run();
  end
endmodule